// File: doc/BRIEF.md
# Circular Return-Address Stack with Interrupt Entry

This block keeps the return addresses of a processor that uses 20-bit program addresses. A call pushes its return address and a return pops it. The newest entry is always shown on a top-of-stack output. The storage is a ring of eight slots, and it never reports an error. A push into a full ring silently replaces the oldest address. A pop frees the top slot and leaves zero behind, so popping more entries than were pushed reads zero.

The same block enters interrupts. A single request input is latched as pending. The request is honoured only at an instruction boundary. When it is taken, the current program counter goes onto the stack and a one-cycle load pulse sends the program counter to the fixed vector 0x0000F. From then on, further requests are masked until an interrupt-return strobe arrives.

Push and pop are plain strobes, not a valid/ready stream. The stack accepts every strobe in the cycle it is presented and never applies back-pressure, so no ready signal exists. The top-of-stack output is valid in every cycle.

Top module: `ret_stack_irq`

## Requirements
- R1: After reset the top-of-stack output is zero and the program-counter load output is low.
- R2: A push makes its data the top of stack from the cycle after the strobe.
- R3: A pop makes the previously pushed entry the top of stack from the cycle after the strobe, in last-in first-out order.
- R4: The ring holds 8 entries. After nine or more pushes the oldest entries are overwritten, so eight pops return the eight newest addresses, newest first.
- R5: Each pop leaves a zero entry behind. A pop from a ring that holds no valid entries shows zero, and a later push works normally.
- R6: A push and a pop in the same cycle replace the top entry, and the entry below it stays unchanged.
- R7: An interrupt request is held pending and taken only in a cycle where the instruction-boundary input is high.
- R8: When an interrupt is taken, the current program counter becomes the top of stack. The load output pulses high for exactly one cycle in the cycle after the boundary, with the load address 0x0000F.
- R9: From the taking of an interrupt until an interrupt-return strobe, requests are masked. They are neither taken nor remembered.
- R10: When an interrupt is taken in a cycle that also carries push or pop strobes, the strobed pop is applied first, then the strobed push, then the program-counter push.
- R11: An interrupt-return strobe while no interrupt is in service has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| push_addr_i | input | 20 | Address to push |
| tos_o | output | 20 | Current top of stack |
| irq_i | input | 1 | Interrupt request |
| insn_end_i | input | 1 | High in the cycle an instruction completes |
| pc_i | input | 20 | Current program counter (return point) |
| irq_ret_i | input | 1 | Interrupt return strobe, ends the mask |
| pc_load_o | output | 1 | One-cycle program-counter load pulse |
| pc_load_addr_o | output | 20 | Vector address to load |

## Verification
Two of the block's functions can fall in the same cycle: the stack operations of the completing instruction and the interrupt's own push of the program counter. The bench provokes this by raising a request together with the boundary input in cycles that also carry a push, and separately a pop. A shift-register reference model in the bench, which fills with zeros, applies pop, then push, then the program-counter push. The bench then compares the top of stack and the load pulse after every edge, including the pops that follow, so that it can see whether the instruction's entry sits under the saved program counter.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_SVC  = 1'b1
  } seq_state_e;

  // Stack operations requested for one cycle, applied in field order:
  // pop, then strobed push, then interrupt push.
  typedef struct packed {
    logic pop;
    logic push;
    logic ipush;
  } stack_op_t;

endpackage

// File: rtl/rstk_ptr_next.sv
module rstk_ptr_next #(
  parameter int PTR_W = 3
) (
  input  logic [PTR_W-1:0] tp_i,
  input  logic             pop_i,
  input  logic             push_i,
  input  logic             ipush_i,
  output logic [PTR_W-1:0] push_slot_o,
  output logic [PTR_W-1:0] irq_slot_o,
  output logic [PTR_W-1:0] tp_next_o
);

  logic [PTR_W-1:0] after_pop;
  logic [PTR_W-1:0] after_push;

  // Modular arithmetic on a power-of-two ring wraps naturally.
  always_comb begin
    after_pop   = pop_i  ? tp_i - 1'b1 : tp_i;
    push_slot_o = after_pop + 1'b1;
    after_push  = push_i ? push_slot_o : after_pop;
    irq_slot_o  = after_push + 1'b1;
    tp_next_o   = ipush_i ? irq_slot_o : after_push;
  end

endmodule

// File: rtl/rstk_store.sv
module rstk_store
  import ret_stack_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stack_op_t         op_i,
  input  logic [ADDR_W-1:0] din_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] tos_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ADDR_W-1:0] mem_q  [DEPTH];
  logic [ADDR_W-1:0] slot_d [DEPTH];
  logic [PTR_W-1:0]  tp_q;
  logic [PTR_W-1:0]  tp_d;
  logic [PTR_W-1:0]  push_slot;
  logic [PTR_W-1:0]  irq_slot;

  rstk_ptr_next #(.PTR_W(PTR_W)) u_ptr (
    .tp_i        (tp_q),
    .pop_i       (op_i.pop),
    .push_i      (op_i.push),
    .ipush_i     (op_i.ipush),
    .push_slot_o (push_slot),
    .irq_slot_o  (irq_slot),
    .tp_next_o   (tp_d)
  );

  // Per-slot next value: interrupt push overrides strobed push,
  // which overrides the zero fill left by a pop.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [PTR_W-1:0] IDX = PTR_W'(g);
    assign slot_d[g] =
        (op_i.ipush && irq_slot  == IDX) ? pc_i  :
        (op_i.push  && push_slot == IDX) ? din_i :
        (op_i.pop   && tp_q      == IDX) ? '0    :
                                           mem_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tp_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      tp_q <= tp_d;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= slot_d[i];
    end
  end

  assign tos_o = mem_q[tp_q];

  p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i.push && !op_i.ipush) |=> (tos_o == $past(din_i)));

  p_irq_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_i.ipush |=> (tos_o == $past(pc_i)));

  p_pop_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i.pop && !op_i.push && !op_i.ipush) |=> (mem_q[$past(tp_q)] == '0));

  p_replace_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i.pop && op_i.push && !op_i.ipush) |=> (tp_q == $past(tp_q)));

endmodule

// File: rtl/rstk_irq_seq.sv
module rstk_irq_seq
  import ret_stack_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic irq_i,
  input  logic insn_end_i,
  input  logic irq_ret_i,
  output logic take_o,
  output logic pc_load_o
);

  seq_state_e state_q, state_d;
  logic       pend_q, pend_d;
  logic       req;

  always_comb begin
    req     = pend_q | irq_i;
    take_o  = (state_q == SEQ_IDLE) && req && insn_end_i;
    state_d = state_q;
    pend_d  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (take_o) state_d = SEQ_SVC;
        else        pend_d  = req;
      end
      SEQ_SVC: begin
        if (irq_ret_i) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_IDLE;
      pend_q    <= 1'b0;
      pc_load_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      pend_q    <= pend_d;
      pc_load_o <= take_o;
    end
  end

  p_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |-> $past(insn_end_i));

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |=> !pc_load_o);

  p_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_SVC && !irq_ret_i) |=> !pc_load_o);

endmodule

// File: rtl/ret_stack_irq.sv
module ret_stack_irq
  import ret_stack_pkg::*;
#(
  parameter int              DEPTH  = 8,
  parameter int              ADDR_W = 20,
  parameter logic [ADDR_W-1:0] VECTOR = 20'h0000F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  output logic [ADDR_W-1:0] tos_o,
  input  logic              irq_i,
  input  logic              insn_end_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              irq_ret_i,
  output logic              pc_load_o,
  output logic [ADDR_W-1:0] pc_load_addr_o
);

  logic      take;
  stack_op_t op;

  rstk_irq_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_i      (irq_i),
    .insn_end_i (insn_end_i),
    .irq_ret_i  (irq_ret_i),
    .take_o     (take),
    .pc_load_o  (pc_load_o)
  );

  assign op.pop   = pop_i;
  assign op.push  = push_i;
  assign op.ipush = take;

  rstk_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .op_i  (op),
    .din_i (push_addr_i),
    .pc_i  (pc_i),
    .tos_o (tos_o)
  );

  assign pc_load_addr_o = VECTOR;

endmodule

// File: tb/ret_stack_irq_tb.sv
module ret_stack_irq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 0, pop_i = 0, irq_i = 0, insn_end_i = 0, irq_ret_i = 0;
  logic [19:0] push_addr_i = '0, pc_i = '0;
  logic [19:0] tos_o, pc_load_addr_o;
  logic        pc_load_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ret_stack_irq u_dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .push_addr_i(push_addr_i), .tos_o(tos_o), .irq_i(irq_i),
    .insn_end_i(insn_end_i), .pc_i(pc_i), .irq_ret_i(irq_ret_i),
    .pc_load_o(pc_load_o), .pc_load_addr_o(pc_load_addr_o)
  );

  // Reference model: m[0] is the top; pops shift in zero at the bottom.
  logic [19:0] m [8];
  bit          m_pend = 0, m_svc = 0;

  logic [19:0] q_tos [$];
  bit          q_ld  [$];
  string       q_tag [$];

  function automatic void m_pop();
    for (int i = 0; i < 7; i++) m[i] = m[i+1];
    m[7] = '0;
  endfunction

  function automatic void m_push(logic [19:0] v);
    for (int i = 7; i > 0; i--) m[i] = m[i-1];
    m[0] = v;
  endfunction

  task automatic cyc(bit pu, bit po, logic [19:0] d, bit irq, bit en,
                     logic [19:0] pc, bit ret, string tag);
    bit take;
    push_i = pu; pop_i = po; push_addr_i = d; irq_i = irq;
    insn_end_i = en; pc_i = pc; irq_ret_i = ret;
    @(posedge clk);
    take = !m_svc && (m_pend || irq) && en;
    if (po) m_pop();
    if (pu) m_push(d);
    if (take) m_push(pc);
    if (take)        begin m_pend = 0; m_svc = 1; end
    else if (!m_svc) m_pend = m_pend || irq;
    else             begin m_pend = 0; if (ret) m_svc = 0; end
    q_tos.push_back(m[0]);
    q_ld.push_back(take);
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  // Monitor: compares the design against the queued expectations.
  initial begin
    forever begin
      @(negedge clk);
      while (q_tos.size() > 0) begin
        logic [19:0] et;
        bit          el;
        string       tg;
        et = q_tos.pop_front();
        el = q_ld.pop_front();
        tg = q_tag.pop_front();
        checks++;
        if (tos_o !== et || pc_load_o !== el ||
            (el && pc_load_addr_o !== 20'h0000F)) begin
          fails++;
          $display("FAIL %s: tos=%h load=%b addr=%h expected tos=%h load=%b addr=0000f",
                   tg, tos_o, pc_load_o, pc_load_addr_o, et, el);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (tos_o !== '0 || pc_load_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: tos=%h load=%b expected tos=00000 load=0", tos_o, pc_load_o);
    end

    // R2 / R4: ten pushes overflow the eight-entry ring
    for (int i = 1; i <= 10; i++)
      cyc(1, 0, 20'hA0000 + 20'(i), 0, 0, '0, 0, (i > 8) ? "R4" : "R2");
    // R3 / R4: eight pops return the eight newest, newest first
    for (int i = 0; i < 8; i++) cyc(0, 1, '0, 0, 0, '0, 0, "R3");
    // R5: underflow reads zero, then a push still works
    cyc(0, 1, '0, 0, 0, '0, 0, "R5");
    cyc(1, 0, 20'h12345, 0, 0, '0, 0, "R5");
    cyc(1, 0, 20'h22222, 0, 0, '0, 0, "R2");
    // R6: simultaneous push and pop replace the top only
    cyc(1, 1, 20'h33333, 0, 0, '0, 0, "R6");
    cyc(0, 1, '0, 0, 0, '0, 0, "R6");
    // R7: request pends while no boundary, taken at the boundary
    cyc(0, 0, '0, 1, 0, 20'h00100, 0, "R7");
    cyc(0, 0, '0, 0, 0, 20'h00101, 0, "R7");
    cyc(0, 0, '0, 0, 1, 20'h00102, 0, "R8");
    cyc(0, 0, '0, 0, 0, 20'h00200, 0, "R8");
    // R9: masked during service, request not remembered
    cyc(0, 0, '0, 1, 1, 20'h00300, 0, "R9");
    cyc(0, 0, '0, 1, 0, 20'h00301, 1, "R9");
    cyc(0, 0, '0, 0, 1, 20'h00302, 0, "R9");
    cyc(0, 0, '0, 0, 1, 20'h00303, 0, "R9");
    // R11: return strobe when idle changes nothing
    cyc(0, 0, '0, 0, 0, '0, 1, "R11");
    cyc(0, 0, '0, 0, 1, 20'h00400, 0, "R11");
    // R10: push and interrupt entry in the same boundary cycle
    cyc(1, 0, 20'h44444, 1, 1, 20'h00500, 0, "R10");
    cyc(0, 1, '0, 0, 0, '0, 1, "R10");
    cyc(0, 1, '0, 0, 0, '0, 0, "R10");
    // R10: pop and interrupt entry in the same boundary cycle
    cyc(1, 0, 20'h55555, 0, 0, '0, 0, "R2");
    cyc(0, 1, '0, 1, 1, 20'h00600, 0, "R10");
    cyc(0, 1, '0, 0, 0, '0, 1, "R10");
    cyc(0, 0, '0, 0, 0, '0, 0, "R10");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule